// File: doc/BRIEF.md
# Timer-Paced Serial DAC Sine Streamer

This block plays one sine period, over and over, into an external 12-bit DAC that takes commands over a serial link. A free-running sample counter counts system clocks up to a programmable compare value and produces a one-cycle sample tick when it gets there. On each tick the block looks up the next of 32 sine samples in a table. It puts a fixed four-bit control code in front of the sample to make a 16-bit command and shifts that command out. The serial link uses a clock at half the system rate, a data line and an active-low select. The DAC load input is held low, so each command takes effect as soon as its select is released.

The compare value is an input port, so the sample rate can be set without touching the table. With a 16 MHz clock and a compare value of 1999, samples go out at 8 kHz and the sine comes out at 250 Hz, which is the sample rate divided by the table length. A tick that arrives while a frame is still shifting is kept as one pending request and served as soon as the link is free. Any further ticks in that time are lost, and a sticky overrun flag records the loss.

Top module: `dac_wave_streamer`

## Requirements
- R1: Each frame carries a 16-bit command. Bits 15..12 are the control code 4'b0011, and bits 11..0 are the table sample.
- R2: The command is shifted most significant bit first, so bit 15 goes first and bit 0 last. The data line changes only while the serial clock is low and holds steady while it is high (clock idles low, the DAC samples on the rising edge).
- R3: The select line goes low on the cycle a frame starts, which is before the first rising serial clock edge. It goes high on the cycle after the last high phase. It stays high for at least one system cycle between frames.
- R4: The DAC load strobe output is low at all times.
- R5: Table entry k holds these values: 2048 at k=0, 4095 at k=8, 2048 at k=16 and 0 at k=24. Between those points the values are 2447, 2831, 3185, 3495, 3750, 3939 and 4056 rising, then mirrored. The lower half is 4096 minus the upper half.
- R6: The table index starts at 0, advances by one for each frame started, and wraps from 31 to 0.
- R7: The sample counter produces a tick every rate_cmp+1 system cycles, counting from reset. A tick that finds the link idle starts a frame on that same clock edge. The serial clock is high for one system cycle and low for one system cycle per bit, which gives 32 cycles per frame.
- R8: A tick that arrives during a frame is held as one pending request and starts the next frame on the first edge at which the link is idle. A tick that arrives while a request is already pending and the link is busy is dropped and sets a sticky overrun output, which only reset clears.
- R9: frame_done is high for exactly one cycle: the cycle in which the select line returns high.
- R10: While reset is asserted and after it is released, select is high, serial clock and data are low, frame_done and overrun are low, and no frame starts before the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_cmp | input | 16 | Sample counter compare value; tick period is rate_cmp+1 cycles |
| spi_sck | output | 1 | Serial clock to the DAC, idles low |
| spi_mosi | output | 1 | Serial data to the DAC |
| spi_cs_n | output | 1 | Active-low frame select |
| dac_load_n | output | 1 | Active-low load strobe, held low |
| frame_done | output | 1 | One-cycle pulse when a frame is released |
| overrun | output | 1 | Sticky flag: a sample tick was dropped |

## Verification
The functions that can land in the same cycle are the release of a frame and the next sample tick, including a tick that arrives just as the pending request is being served. A compare value of 19 gives a tick period of 20 cycles, shorter than the 33-cycle frame. That makes ticks land during shifting, on release edges and on pending service edges, so pending hand-off and overrun both come into play. A behavioural model in the bench reproduces the timeline of select, serial clock, data, frame_done and overrun from the requirements and is compared against the ports on every cycle. Each captured command word is also decoded from the serial pins and compared with the expected table entry.

// File: rtl/dws_pkg.sv
package dws_pkg;

    localparam int CTRL_W   = 4;
    localparam int SAMPLE_W = 12;
    localparam int WORD_W   = CTRL_W + SAMPLE_W;
    localparam int IDX_W    = 5;
    localparam int TBL_LEN  = 1 << IDX_W;

    typedef enum logic {
        LINK_IDLE  = 1'b0,
        LINK_SHIFT = 1'b1
    } link_state_e;

    // First quarter of the sine period, points 0..8
    function automatic logic [12:0] quarter_pt(input logic [3:0] k);
        logic [12:0] v;
        case (k)
            4'd0:    v = 13'd2048;
            4'd1:    v = 13'd2447;
            4'd2:    v = 13'd2831;
            4'd3:    v = 13'd3185;
            4'd4:    v = 13'd3495;
            4'd5:    v = 13'd3750;
            4'd6:    v = 13'd3939;
            4'd7:    v = 13'd4056;
            default: v = 13'd4095;
        endcase
        return v;
    endfunction

    // Full 32-point period built from the quarter by mirroring
    function automatic logic [11:0] sine_entry(input logic [4:0] i);
        logic [3:0]  k;
        logic [3:0]  km;
        logic [12:0] v;
        k  = {1'b0, i[2:0]};
        km = 4'd8 - k;
        case (i[4:3])
            2'd0: v = quarter_pt(k);
            2'd1: v = quarter_pt(km);
            2'd2: v = 13'd4096 - quarter_pt(k);
            default: v = (k == 4'd0) ? 13'd0 : (13'd4096 - quarter_pt(km));
        endcase
        return v[11:0];
    endfunction

endpackage

// File: rtl/dws_tick_gen.sv
module dws_tick_gen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cmp,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_state_t;

    tick_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt == cmp);
        if (tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (s_q.cnt == '0)); // R7

endmodule

// File: rtl/dws_sine_rom.sv
module dws_sine_rom #(
    parameter int IDX_W    = dws_pkg::IDX_W,
    parameter int SAMPLE_W = dws_pkg::SAMPLE_W
) (
    input  logic [IDX_W-1:0]    idx,
    output logic [SAMPLE_W-1:0] sample
);

    localparam int DEPTH = 1 << IDX_W;

    logic [SAMPLE_W-1:0] rom_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign rom_w[g] = SAMPLE_W'(dws_pkg::sine_entry(5'(g)));
    end

    assign sample = rom_w[idx];

endmodule

// File: rtl/dws_frame_shifter.sv
module dws_frame_shifter #(
    parameter int WORD_W = dws_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              cs_n,
    output logic              done
);

    localparam int BIT_W = $clog2(WORD_W);

    typedef struct packed {
        dws_pkg::link_state_e st;
        logic [WORD_W-1:0]    shreg;
        logic [BIT_W-1:0]     bits_left;
        logic                 sck;
        logic                 mosi;
        logic                 cs_n;
        logic                 done;
    } link_t;

    link_t l_d, l_q;

    always_comb begin
        l_d      = l_q;
        l_d.done = 1'b0;
        case (l_q.st)
            dws_pkg::LINK_IDLE: begin
                if (start) begin
                    l_d.st        = dws_pkg::LINK_SHIFT;
                    l_d.mosi      = word[WORD_W-1];
                    l_d.shreg     = word << 1;
                    l_d.bits_left = BIT_W'(WORD_W - 1);
                    l_d.cs_n      = 1'b0;
                    l_d.sck       = 1'b0;
                end
            end
            default: begin
                if (!l_q.sck) begin
                    l_d.sck = 1'b1;
                end else begin
                    l_d.sck = 1'b0;
                    if (l_q.bits_left == '0) begin
                        l_d.st   = dws_pkg::LINK_IDLE;
                        l_d.cs_n = 1'b1;
                        l_d.mosi = 1'b0;
                        l_d.done = 1'b1;
                    end else begin
                        l_d.bits_left = l_q.bits_left - 1'b1;
                        l_d.mosi      = l_q.shreg[WORD_W-1];
                        l_d.shreg     = l_q.shreg << 1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q       <= '0;
            l_q.st    <= dws_pkg::LINK_IDLE;
            l_q.cs_n  <= 1'b1;
        end else begin
            l_q <= l_d;
        end
    end

    assign busy = (l_q.st == dws_pkg::LINK_SHIFT);
    assign sck  = l_q.sck;
    assign mosi = l_q.mosi;
    assign cs_n = l_q.cs_n;
    assign done = l_q.done;

    AST_SCK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n); // R3
    AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(mosi)); // R2
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(!cs_n))); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

endmodule

// File: rtl/dac_wave_streamer.sv
module dac_wave_streamer #(
    parameter int          CMP_W    = 16,
    parameter int          IDX_W    = dws_pkg::IDX_W,
    parameter int          SAMPLE_W = dws_pkg::SAMPLE_W,
    parameter int          CTRL_W   = dws_pkg::CTRL_W,
    parameter logic [3:0]  CTRL_CODE = 4'b0011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] rate_cmp,
    output logic             spi_sck,
    output logic             spi_mosi,
    output logic             spi_cs_n,
    output logic             dac_load_n,
    output logic             frame_done,
    output logic             overrun
);

    localparam int WORD_W = CTRL_W + SAMPLE_W;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             pend;
        logic             ovr;
    } seq_t;

    seq_t s_d, s_q;

    logic                tick;
    logic                busy;
    logic                start;
    logic [SAMPLE_W-1:0] sample;
    logic [WORD_W-1:0]   word;

    dws_tick_gen #(.CNT_W(CMP_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .cmp   (rate_cmp),
        .tick  (tick)
    );

    dws_sine_rom #(.IDX_W(IDX_W), .SAMPLE_W(SAMPLE_W)) u_rom (
        .idx    (s_q.idx),
        .sample (sample)
    );

    assign word = {CTRL_W'(CTRL_CODE), sample};

    always_comb begin
        s_d   = s_q;
        start = !busy && (tick || s_q.pend);
        if (start) begin
            s_d.idx  = s_q.idx + 1'b1;
            s_d.pend = s_q.pend && tick;
        end else if (tick) begin
            s_d.pend = 1'b1;
            if (s_q.pend) begin
                s_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    dws_frame_shifter #(.WORD_W(WORD_W)) u_link (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .word  (word),
        .busy  (busy),
        .sck   (spi_sck),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n),
        .done  (frame_done)
    );

    assign dac_load_n = 1'b0;
    assign overrun    = s_q.ovr;

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (s_q.idx == $past(s_q.idx) + 1'b1)); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R8
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !spi_cs_n); // R3

endmodule

// File: tb/dac_wave_streamer_tb.sv
module dac_wave_streamer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rate_cmp = 16'd39;
    logic        spi_sck, spi_mosi, spi_cs_n, dac_load_n, frame_done, overrun;

    always #5 clk = ~clk;

    dac_wave_streamer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_cmp   (rate_cmp),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi),
        .spi_cs_n   (spi_cs_n),
        .dac_load_n (dac_load_n),
        .frame_done (frame_done),
        .overrun    (overrun)
    );

    int tbl [32] = '{2048, 2447, 2831, 3185, 3495, 3750, 3939, 4056,
                     4095, 4056, 3939, 3750, 3495, 3185, 2831, 2447,
                     2048, 1649, 1265,  911,  601,  346,  157,   40,
                        0,   40,  157,  346,  601,  911, 1265, 1649};

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural model
    int m_cnt, m_t, m_idx, m_word;
    bit m_pend, m_ovr, m_done;
    int exp_q [$];
    int exp_idx_q [$];
    int cap;

    task automatic model_reset();
        m_cnt = 0; m_t = -1; m_idx = 0; m_word = 0;
        m_pend = 0; m_ovr = 0; m_done = 0;
        exp_q.delete(); exp_idx_q.delete();
        cap = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            model_reset();
        end else begin
            bit tk, bz, st;
            tk = (m_cnt == int'(rate_cmp));
            m_cnt = tk ? 0 : m_cnt + 1;
            bz = (m_t >= 0 && m_t < 32);
            st = !bz && (tk || m_pend);
            m_done = 0;
            if (bz) begin
                m_t++;
                if (m_t == 32) m_done = 1;
            end
            if (st) begin
                m_t = 0;
                m_word = (3 << 12) | tbl[m_idx];
                exp_q.push_back(m_word);
                exp_idx_q.push_back(m_idx);
                m_idx = (m_idx + 1) % 32;
                m_pend = m_pend && tk;
            end else if (tk) begin
                if (m_pend) m_ovr = 1;
                m_pend = 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            int e_cs, e_sck, e_mosi;
            bit act_frame;
            act_frame = (m_t >= 0 && m_t < 32);
            e_cs   = act_frame ? 0 : 1;
            e_sck  = act_frame ? (m_t % 2) : 0;
            e_mosi = act_frame ? ((m_word >> (15 - m_t / 2)) & 1) : 0;
            check(spi_cs_n == e_cs,         "R3/R7 select", spi_cs_n, e_cs);
            check(spi_sck == e_sck,         "R7 serial clock", spi_sck, e_sck);
            check(spi_mosi == e_mosi,       "R2 data bit", spi_mosi, e_mosi);
            check(frame_done == m_done,     "R9 frame_done", frame_done, m_done);
            check(overrun == m_ovr,         "R8 overrun", overrun, m_ovr);
            check(dac_load_n == 1'b0,       "R4 load strobe", dac_load_n, 0);
            if (spi_sck) cap = ((cap << 1) | spi_mosi) & 16'hFFFF;
            if (frame_done) begin
                int ew, ei;
                ew = exp_q.size() ? exp_q.pop_front() : -1;
                ei = exp_idx_q.size() ? exp_idx_q.pop_front() : -1;
                check(((cap >> 12) & 15) == 3, "R1 control code", (cap >> 12) & 15, 3);
                check(cap == ew, "R1/R5 command word", cap, ew);
                if (ei == 0)  check((cap & 12'hFFF) == 2048, "R6 wrap to entry 0", cap & 12'hFFF, 2048);
                if (ei == 8)  check((cap & 12'hFFF) == 4095, "R5 peak entry", cap & 12'hFFF, 4095);
                if (ei == 24) check((cap & 12'hFFF) == 0, "R5 trough entry", cap & 12'hFFF, 0);
                cap = 0;
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        report();
    end

    task automatic reset_check();
        check(spi_cs_n == 1'b1,  "R10 select in reset", spi_cs_n, 1);
        check(spi_sck == 1'b0,   "R10 clock in reset", spi_sck, 0);
        check(spi_mosi == 1'b0,  "R10 data in reset", spi_mosi, 0);
        check(frame_done == 1'b0, "R10 done in reset", frame_done, 0);
        check(overrun == 1'b0,   "R10 overrun in reset", overrun, 0);
    endtask

    initial begin
        // phase A: period 40, no overrun, two full wraps
        rst_n = 1'b0; rate_cmp = 16'd39;
        repeat (3) @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(spi_cs_n == 1'b1, "R10 idle before first tick", spi_cs_n, 1);
        repeat (40 * 70) @(negedge clk);
        check(overrun == 1'b0, "R8 no overrun at slow rate", overrun, 0);

        // phase B: period 20, ticks during frames, pending and overrun
        rst_n = 1'b0; rate_cmp = 16'd19;
        repeat (2) @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        repeat (600) @(negedge clk);
        check(overrun == 1'b1, "R8 overrun set under fast ticks", overrun, 1);

        // phase C: default rate
        rst_n = 1'b0; rate_cmp = 16'd1999;
        repeat (2) @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        repeat (2000 * 3 + 100) @(negedge clk);
        check(overrun == 1'b0, "R8 no overrun at default rate", overrun, 0);
        report();
    end

endmodule